// File: doc/BRIEF.md
# Calendar Validator and BCD Codec

This block sits between a processor-side view of wall-clock time and a battery-backed timekeeper that stores its fields as packed BCD bytes with only a two-digit year. On the encode path it takes a binary date and time with a full four-digit year. It decides whether the combination is a real calendar moment inside a fixed hundred-year window. When it is, it produces the six BCD register bytes. The day limit for February follows the full Gregorian leap rule.

On the decode path it takes six BCD bytes read back from the timekeeper and returns binary fields with a full year. Two-digit years are placed into the same hundred-year window: low values go to the later century and high values to the earlier one. The top bit of the seconds byte carries an oscillator-stop flag, and it is ignored on this path.

Each path answers one clock after its request strobe. The answer comes with a done pulse and an error flag. On an error the output bytes or fields keep their last good values.

Top module: `cal_bcd_codec`

## Requirements
- R1: A request strobe on either path produces a done pulse on that path exactly one cycle later; without a strobe, done stays low and the error flag stays low.
- R2: The encode path flags an error for any year below 1970 or above 2069.
- R3: The encode path flags an error for month 0, for a month above 12, and for day 0.
- R4: The day limits are 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 for months 1 to 12; any larger day is an error.
- R5: February allows day 29 when the year is divisible by 400, or by 4 but not by 100.
- R6: An hour of 24 or more, or a minute or second of 60 or more, is an error.
- R7: Each encoded byte holds the tens digit in bits 7:4 and the units digit in bits 3:0. The year byte is the year minus 2000 for years from 2000, and the year minus 1900 otherwise.
- R8: After a failed encode the error flag is high and all six BCD outputs keep their previous values; between requests they also hold.
- R9: The decode path maps a two-digit year of 69 or below to 2000 plus that value, and 70 to 99 to 1900 plus that value.
- R10: The decode path ignores bit 7 of the seconds byte.
- R11: The decode path flags an error when any nibble it uses exceeds 9, and the decoded fields then keep their previous values.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid | input | 1 | Encode request strobe |
| enc_year | input | 12 | Binary full year |
| enc_month | input | 4 | Binary month |
| enc_day | input | 5 | Binary day of month |
| enc_hour | input | 5 | Binary hour |
| enc_min | input | 6 | Binary minute |
| enc_sec | input | 6 | Binary second |
| enc_done | output | 1 | Encode result present |
| enc_err | output | 1 | Encode rejected |
| bcd_year | output | 8 | Two-digit year, BCD |
| bcd_month | output | 8 | Month, BCD |
| bcd_day | output | 8 | Day, BCD |
| bcd_hour | output | 8 | Hour, BCD |
| bcd_min | output | 8 | Minute, BCD |
| bcd_sec | output | 8 | Second, BCD |
| dec_valid | input | 1 | Decode request strobe |
| dec_in_year | input | 8 | Year byte |
| dec_in_month | input | 8 | Month byte |
| dec_in_day | input | 8 | Day byte |
| dec_in_hour | input | 8 | Hour byte |
| dec_in_min | input | 8 | Minute byte |
| dec_in_sec | input | 8 | Seconds byte, bit 7 ignored |
| dec_done | output | 1 | Decode result present |
| dec_err | output | 1 | Decode rejected |
| dec_year | output | 12 | Full binary year |
| dec_month | output | 4 | Binary month |
| dec_day | output | 5 | Binary day |
| dec_hour | output | 5 | Binary hour |
| dec_min | output | 6 | Binary minute |
| dec_sec | output | 6 | Binary second |

## Verification
The assertions watch the properties that hold on every cycle:
- the one-cycle done timing;
- the holding of every output while no request is pending or after a rejection;
- digit legality of accepted encodes;
- rejection of out-of-window years and hours;
- the decoded year landing inside the window.

Whether each accepted byte carries the right digits cannot be seen from one cycle alone. The same is true of the month-by-month day limits and leap Februaries. These are shown by the bench's directed cases at the century, window and February edges, and by random requests compared with reference functions.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int NFIELD = 6;

  // two decimal digits, tens in the upper nibble
  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic digits_ok(input logic [7:0] b);
    return (b[7:4] <= 4'd9) && (b[3:0] <= 4'd9);
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                     return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  return 5'd30;
      default:                  return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_check.sv
module cal_check
  import cal_pkg::*;
#(
  parameter int YEAR_W   = 12,
  parameter int EPOCH_LO = 1970
) (
  input  logic [YEAR_W-1:0] year,
  input  logic [3:0]        month,
  input  logic [4:0]        day,
  input  logic [4:0]        hour,
  input  logic [5:0]        minute,
  input  logic [5:0]        second,
  output logic              ok
);
  localparam int EPOCH_HI = EPOCH_LO + 99;

  logic leap, year_ok, date_ok, time_ok;

  always_comb begin
    leap    = ((year % YEAR_W'(4)) == '0 && (year % YEAR_W'(100)) != '0) ||
              ((year % YEAR_W'(400)) == '0);
    year_ok = (year >= YEAR_W'(EPOCH_LO)) && (year <= YEAR_W'(EPOCH_HI));
    date_ok = (month != 4'd0) && (month <= 4'd12) && (day != 5'd0) &&
              (day <= month_len(month, leap));
    time_ok = (hour < 5'd24) && (minute < 6'd60) && (second < 6'd60);
    ok      = year_ok && date_ok && time_ok;
  end
endmodule

// File: rtl/cal_bcd_enc.sv
module cal_bcd_enc
  import cal_pkg::*;
#(
  parameter int YEAR_W   = 12,
  parameter int EPOCH_LO = 1970
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [YEAR_W-1:0] year,
  input  logic [3:0]        month,
  input  logic [4:0]        day,
  input  logic [4:0]        hour,
  input  logic [5:0]        minute,
  input  logic [5:0]        second,
  output logic              out_done,
  output logic              out_err,
  output logic [7:0]        b_year,
  output logic [7:0]        b_month,
  output logic [7:0]        b_day,
  output logic [7:0]        b_hour,
  output logic [7:0]        b_min,
  output logic [7:0]        b_sec
);
  localparam int CENT_LO = (EPOCH_LO / 100) * 100;
  localparam int CENT_HI = CENT_LO + 100;

  logic       ok;
  logic [6:0] yy;

  cal_check #(.YEAR_W(YEAR_W), .EPOCH_LO(EPOCH_LO)) u_check (
    .year(year), .month(month), .day(day), .hour(hour),
    .minute(minute), .second(second), .ok(ok)
  );

  assign yy = (year >= YEAR_W'(CENT_HI)) ? 7'(year - YEAR_W'(CENT_HI))
                                         : 7'(year - YEAR_W'(CENT_LO));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done <= 1'b0;
      out_err  <= 1'b0;
      b_year   <= '0;
      b_month  <= '0;
      b_day    <= '0;
      b_hour   <= '0;
      b_min    <= '0;
      b_sec    <= '0;
    end else begin
      out_done <= in_valid;
      out_err  <= in_valid && !ok;
      if (in_valid && ok) begin
        b_year  <= to_bcd(yy);
        b_month <= to_bcd(7'(month));
        b_day   <= to_bcd(7'(day));
        b_hour  <= to_bcd(7'(hour));
        b_min   <= to_bcd(7'(minute));
        b_sec   <= to_bcd(7'(second));
      end
    end
  end
endmodule

// File: rtl/cal_bcd_dec.sv
module cal_bcd_dec
  import cal_pkg::*;
#(
  parameter int YEAR_W   = 12,
  parameter int EPOCH_LO = 1970
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [NFIELD*8-1:0]   raw_bytes,
  output logic                  out_done,
  output logic                  out_err,
  output logic [YEAR_W-1:0]     year,
  output logic [3:0]            month,
  output logic [4:0]            day,
  output logic [4:0]            hour,
  output logic [5:0]            minute,
  output logic [5:0]            second
);
  localparam int CENT_LO = (EPOCH_LO / 100) * 100;
  localparam int CENT_HI = CENT_LO + 100;
  localparam int PIVOT   = EPOCH_LO - CENT_LO;

  logic [7:0]        clean [NFIELD];
  logic [6:0]        bin   [NFIELD];
  logic [NFIELD-1:0] good;
  logic [YEAR_W-1:0] full_year;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    if (i == F_SEC) begin : g_halt_mask
      assign clean[i] = raw_bytes[i*8 +: 8] & 8'h7F;
    end else begin : g_plain
      assign clean[i] = raw_bytes[i*8 +: 8];
    end
    assign good[i] = digits_ok(clean[i]);
    assign bin[i]  = from_bcd(clean[i]);
  end

  assign full_year = (bin[F_YEAR] < 7'(PIVOT)) ?
                     YEAR_W'(CENT_HI) + YEAR_W'(bin[F_YEAR]) :
                     YEAR_W'(CENT_LO) + YEAR_W'(bin[F_YEAR]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done <= 1'b0;
      out_err  <= 1'b0;
      year     <= '0;
      month    <= '0;
      day      <= '0;
      hour     <= '0;
      minute   <= '0;
      second   <= '0;
    end else begin
      out_done <= in_valid;
      out_err  <= in_valid && !(&good);
      if (in_valid && (&good)) begin
        year   <= full_year;
        month  <= 4'(bin[F_MON]);
        day    <= 5'(bin[F_DAY]);
        hour   <= 5'(bin[F_HOUR]);
        minute <= 6'(bin[F_MIN]);
        second <= 6'(bin[F_SEC]);
      end
    end
  end
endmodule

// File: rtl/cal_bcd_codec.sv
module cal_bcd_codec
  import cal_pkg::*;
#(
  parameter int YEAR_W   = 12,
  parameter int EPOCH_LO = 1970
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid,
  input  logic [YEAR_W-1:0] enc_year,
  input  logic [3:0]        enc_month,
  input  logic [4:0]        enc_day,
  input  logic [4:0]        enc_hour,
  input  logic [5:0]        enc_min,
  input  logic [5:0]        enc_sec,
  output logic              enc_done,
  output logic              enc_err,
  output logic [7:0]        bcd_year,
  output logic [7:0]        bcd_month,
  output logic [7:0]        bcd_day,
  output logic [7:0]        bcd_hour,
  output logic [7:0]        bcd_min,
  output logic [7:0]        bcd_sec,
  input  logic              dec_valid,
  input  logic [7:0]        dec_in_year,
  input  logic [7:0]        dec_in_month,
  input  logic [7:0]        dec_in_day,
  input  logic [7:0]        dec_in_hour,
  input  logic [7:0]        dec_in_min,
  input  logic [7:0]        dec_in_sec,
  output logic              dec_done,
  output logic              dec_err,
  output logic [YEAR_W-1:0] dec_year,
  output logic [3:0]        dec_month,
  output logic [4:0]        dec_day,
  output logic [4:0]        dec_hour,
  output logic [5:0]        dec_min,
  output logic [5:0]        dec_sec
);
  logic [NFIELD*8-1:0] raw_bytes;

  always_comb begin
    raw_bytes = '0;
    raw_bytes[F_YEAR*8 +: 8] = dec_in_year;
    raw_bytes[F_MON*8  +: 8] = dec_in_month;
    raw_bytes[F_DAY*8  +: 8] = dec_in_day;
    raw_bytes[F_HOUR*8 +: 8] = dec_in_hour;
    raw_bytes[F_MIN*8  +: 8] = dec_in_min;
    raw_bytes[F_SEC*8  +: 8] = dec_in_sec;
  end

  cal_bcd_enc #(.YEAR_W(YEAR_W), .EPOCH_LO(EPOCH_LO)) u_enc (
    .clk(clk), .rst(rst), .in_valid(enc_valid),
    .year(enc_year), .month(enc_month), .day(enc_day),
    .hour(enc_hour), .minute(enc_min), .second(enc_sec),
    .out_done(enc_done), .out_err(enc_err),
    .b_year(bcd_year), .b_month(bcd_month), .b_day(bcd_day),
    .b_hour(bcd_hour), .b_min(bcd_min), .b_sec(bcd_sec)
  );

  cal_bcd_dec #(.YEAR_W(YEAR_W), .EPOCH_LO(EPOCH_LO)) u_dec (
    .clk(clk), .rst(rst), .in_valid(dec_valid), .raw_bytes(raw_bytes),
    .out_done(dec_done), .out_err(dec_err),
    .year(dec_year), .month(dec_month), .day(dec_day),
    .hour(dec_hour), .minute(dec_min), .second(dec_sec)
  );
endmodule

// File: rtl/cal_codec_chk.sv
module cal_codec_chk #(
  parameter int YEAR_W   = 12,
  parameter int EPOCH_LO = 1970
) (
  input logic              clk,
  input logic              rst,
  input logic              enc_valid,
  input logic [YEAR_W-1:0] enc_year,
  input logic [4:0]        enc_hour,
  input logic              enc_done,
  input logic              enc_err,
  input logic [7:0]        bcd_year,
  input logic [7:0]        bcd_month,
  input logic [7:0]        bcd_day,
  input logic [7:0]        bcd_hour,
  input logic [7:0]        bcd_min,
  input logic [7:0]        bcd_sec,
  input logic              dec_valid,
  input logic              dec_done,
  input logic              dec_err,
  input logic [YEAR_W-1:0] dec_year,
  input logic [3:0]        dec_month,
  input logic [4:0]        dec_day,
  input logic [4:0]        dec_hour,
  input logic [5:0]        dec_min,
  input logic [5:0]        dec_sec
);
  logic [47:0] enc_bus;
  logic [YEAR_W+25:0] dec_bus;
  logic digits_legal;

  assign enc_bus = {bcd_year, bcd_month, bcd_day, bcd_hour, bcd_min, bcd_sec};
  assign dec_bus = {dec_year, dec_month, dec_day, dec_hour, dec_min, dec_sec};

  always_comb begin
    digits_legal = 1'b1;
    for (int k = 0; k < 12; k++)
      if (enc_bus[k*4 +: 4] > 4'd9) digits_legal = 1'b0;
  end

  a_r1_enc_done: assert property (@(posedge clk) disable iff (rst)
    enc_valid |=> enc_done);
  a_r1_enc_quiet: assert property (@(posedge clk) disable iff (rst)
    !enc_valid |=> (!enc_done && !enc_err));
  a_r1_dec_done: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> dec_done);
  a_r1_dec_quiet: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> (!dec_done && !dec_err));
  a_r2_year_window: assert property (@(posedge clk) disable iff (rst)
    (enc_valid && (enc_year < YEAR_W'(EPOCH_LO) || enc_year > YEAR_W'(EPOCH_LO + 99)))
    |=> enc_err);
  a_r6_hour_limit: assert property (@(posedge clk) disable iff (rst)
    (enc_valid && enc_hour >= 5'd24) |=> enc_err);
  a_r7_digits: assert property (@(posedge clk) disable iff (rst)
    (enc_done && !enc_err) |-> digits_legal);
  a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
    enc_err |-> $stable(enc_bus));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !enc_done |-> $stable(enc_bus));
  a_r9_dec_window: assert property (@(posedge clk) disable iff (rst)
    (dec_done && !dec_err) |->
      (dec_year >= YEAR_W'(EPOCH_LO) && dec_year <= YEAR_W'(EPOCH_LO + 99)));
  a_r11_dec_hold: assert property (@(posedge clk) disable iff (rst)
    (dec_err || !dec_done) |-> $stable(dec_bus));
endmodule

bind cal_bcd_codec cal_codec_chk #(.YEAR_W(YEAR_W), .EPOCH_LO(EPOCH_LO)) u_codec_chk (.*);

// File: tb/cal_bcd_codec_test.sv
module cal_bcd_codec_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        enc_valid = 0;
  logic [11:0] enc_year = 0;
  logic [3:0]  enc_month = 0;
  logic [4:0]  enc_day = 0, enc_hour = 0;
  logic [5:0]  enc_min = 0, enc_sec = 0;
  logic        enc_done, enc_err;
  logic [7:0]  bcd_year, bcd_month, bcd_day, bcd_hour, bcd_min, bcd_sec;
  logic        dec_valid = 0;
  logic [7:0]  dec_in_year = 0, dec_in_month = 0, dec_in_day = 0;
  logic [7:0]  dec_in_hour = 0, dec_in_min = 0, dec_in_sec = 0;
  logic        dec_done, dec_err;
  logic [11:0] dec_year;
  logic [3:0]  dec_month;
  logic [4:0]  dec_day, dec_hour;
  logic [5:0]  dec_min, dec_sec;

  cal_bcd_codec uut (.*);

  int checks = 0, errors = 0, cyc = 0;
  int m_by, m_bmo, m_bd, m_bh, m_bmi, m_bs;
  int m_dy, m_dmo, m_dd, m_dh, m_dmi, m_ds;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit ref_ok(int y, int mo, int d, int h, int mi, int s);
    bit lp;
    int lim;
    if (y < 1970 || y > 2069) return 0;
    if (mo < 1 || mo > 12 || d < 1) return 0;
    lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
    if (mo == 2) lim = lp ? 29 : 28;
    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) lim = 30;
    else lim = 31;
    if (d > lim) return 0;
    if (h > 23 || mi > 59 || s > 59) return 0;
    return 1;
  endfunction

  function automatic int ref_bcd(int v);
    return ((v / 10) * 16) + (v % 10);
  endfunction

  function automatic int ref_unbcd(int b);
    return (b / 16) * 10 + (b % 16);
  endfunction

  function automatic bit ref_digits(int b);
    return (b / 16) <= 9 && (b % 16) <= 9;
  endfunction

  task automatic run_enc(string req, int y, int mo, int d, int h, int mi, int s);
    bit ok;
    @(negedge clk);
    enc_year = 12'(y); enc_month = 4'(mo); enc_day = 5'(d);
    enc_hour = 5'(h);  enc_min = 6'(mi);   enc_sec = 6'(s);
    enc_valid = 1;
    ok = ref_ok(y, mo, d, h, mi, s);
    if (ok) begin
      m_by = ref_bcd(y >= 2000 ? y - 2000 : y - 1900);
      m_bmo = ref_bcd(mo); m_bd = ref_bcd(d); m_bh = ref_bcd(h);
      m_bmi = ref_bcd(mi); m_bs = ref_bcd(s);
    end
    @(negedge clk);
    enc_valid = 0;
    chk({req, " R1"}, "enc_done", int'(enc_done), 1);
    chk(req, "enc_err", int'(enc_err), ok ? 0 : 1);
    chk({req, " R7/R8"}, "bcd_year", int'(bcd_year), m_by);
    chk({req, " R7/R8"}, "bcd_month", int'(bcd_month), m_bmo);
    chk({req, " R7/R8"}, "bcd_day", int'(bcd_day), m_bd);
    chk({req, " R7/R8"}, "bcd_hour", int'(bcd_hour), m_bh);
    chk({req, " R7/R8"}, "bcd_min", int'(bcd_min), m_bmi);
    chk({req, " R7/R8"}, "bcd_sec", int'(bcd_sec), m_bs);
  endtask

  task automatic run_dec(string req, int by, int bmo, int bd, int bh, int bmi, int bs);
    bit ok;
    int yy;
    @(negedge clk);
    dec_in_year = 8'(by); dec_in_month = 8'(bmo); dec_in_day = 8'(bd);
    dec_in_hour = 8'(bh); dec_in_min = 8'(bmi);   dec_in_sec = 8'(bs);
    dec_valid = 1;
    ok = ref_digits(by) && ref_digits(bmo) && ref_digits(bd) &&
         ref_digits(bh) && ref_digits(bmi) && ref_digits(bs % 128);
    if (ok) begin
      yy = ref_unbcd(by);
      m_dy = (yy <= 69) ? 2000 + yy : 1900 + yy;
      m_dmo = ref_unbcd(bmo) % 16; m_dd = ref_unbcd(bd) % 32;
      m_dh = ref_unbcd(bh) % 32;   m_dmi = ref_unbcd(bmi) % 64;
      m_ds = ref_unbcd(bs % 128) % 64;
    end
    @(negedge clk);
    dec_valid = 0;
    chk({req, " R1"}, "dec_done", int'(dec_done), 1);
    chk({req, " R11"}, "dec_err", int'(dec_err), ok ? 0 : 1);
    chk({req, " R9"}, "dec_year", int'(dec_year), m_dy);
    chk(req, "dec_month", int'(dec_month), m_dmo);
    chk(req, "dec_day", int'(dec_day), m_dd);
    chk(req, "dec_hour", int'(dec_hour), m_dh);
    chk(req, "dec_min", int'(dec_min), m_dmi);
    chk({req, " R10"}, "dec_sec", int'(dec_sec), m_ds);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R1: actual %0d cycles expected fewer than 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240229));
    m_by = 0; m_bmo = 0; m_bd = 0; m_bh = 0; m_bmi = 0; m_bs = 0;
    m_dy = 0; m_dmo = 0; m_dd = 0; m_dh = 0; m_dmi = 0; m_ds = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "enc_done", int'(enc_done), 0);
    chk("R12", "bcd_year", int'(bcd_year), 0);
    chk("R12", "dec_done", int'(dec_done), 0);
    chk("R12", "dec_year", int'(dec_year), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 idle", "enc_done", int'(enc_done), 0);

    run_enc("R7 window top", 2069, 12, 31, 23, 59, 59);
    run_enc("R7 window base", 1970, 1, 1, 0, 0, 0);
    run_enc("R2 below window", 1969, 6, 15, 12, 0, 0);
    run_enc("R2 above window", 2070, 1, 1, 0, 0, 0);
    run_enc("R5 leap by 400", 2000, 2, 29, 1, 2, 3);
    run_enc("R5 leap by 4", 2024, 2, 29, 10, 20, 30);
    run_enc("R5 non-leap Feb 29", 2023, 2, 29, 10, 20, 30);
    run_enc("R4 Feb 28", 2023, 2, 28, 4, 5, 6);
    run_enc("R4 April 31", 2031, 4, 31, 0, 0, 0);
    run_enc("R4 Nov 30", 1999, 11, 30, 7, 8, 9);
    run_enc("R3 month zero", 2010, 0, 10, 0, 0, 0);
    run_enc("R3 month thirteen", 2010, 13, 10, 0, 0, 0);
    run_enc("R3 day zero", 2010, 5, 0, 0, 0, 0);
    run_enc("R6 hour 24", 2010, 5, 5, 24, 0, 0);
    run_enc("R6 minute 60", 2010, 5, 5, 0, 60, 0);
    run_enc("R6 second 60", 2010, 5, 5, 0, 0, 60);
    @(negedge clk);
    chk("R8 idle hold", "bcd_day", int'(bcd_day), m_bd);
    chk("R1 idle", "enc_err", int'(enc_err), 0);

    run_dec("R9 year 69", 8'h69, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    run_dec("R9 year 70", 8'h70, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    run_dec("R9 year 00", 8'h00, 8'h02, 8'h29, 8'h12, 8'h34, 8'h56);
    run_dec("R9 year 99", 8'h99, 8'h10, 8'h15, 8'h08, 8'h09, 8'h10);
    run_dec("R10 halt bit", 8'h45, 8'h07, 8'h04, 8'h13, 8'h37, 8'hD9);
    run_dec("R11 bad month nibble", 8'h21, 8'h1A, 8'h04, 8'h13, 8'h37, 8'h00);
    run_dec("R11 bad year nibble", 8'hA0, 8'h01, 8'h04, 8'h13, 8'h37, 8'h00);

    for (int n = 0; n < 400; n++) begin
      int y, mo, d, h, mi, s;
      y = 1960 + int'($urandom % 120); mo = int'($urandom % 14);
      d = int'($urandom % 32);        h = int'($urandom % 26);
      mi = int'($urandom % 62);       s = int'($urandom % 62);
      run_enc("R2-R8 random", y, mo, d, h, mi, s);
    end
    for (int n = 0; n < 400; n++) begin
      int b[6];
      for (int k = 0; k < 6; k++) begin
        if ($urandom % 8 == 0) b[k] = int'($urandom % 256);
        else b[k] = ref_bcd(int'($urandom % 100));
      end
      if ($urandom % 2 == 1) b[5] = (b[5] % 128) | 128;
      run_dec("R9/R10/R11 random", b[0], b[1], b[2], b[3], b[4], b[5]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule